// File: doc/BRIEF.md
# Differential Gray Sample Encoder

This block re-codes a stream of 10-bit converter samples so that fewer output bits toggle from one sample to the next. In differential mode each valid sample is replaced by its difference from the valid sample two positions earlier. This means that two interleaved colour phases are each differenced against their own phase. The difference wraps within the sample width. A Gray mapping can then be applied to whatever value results. Both options can be enabled at the same time.

A receiver needs absolute values to rebuild the stream. For that reason, two consecutive samples after each line-reference pulse leave the block undifferenced, as standard samples. They still pass through the Gray mapping when it is enabled. A 2-bit field chooses where the standard pair sits, counted from the pulse.

The reference pulse has a selectable active level. It can be sampled on either clock edge, and only its leading edge restarts the count. The coded result is held in an output register and updates one clock after each valid sample.

Top module: `diff_gray_encoder`

## Requirements
- R1: With differencing and Gray both off, each valid sample appears unchanged on `code_o` one clock after it is presented.
- R2: With Gray on and differencing off, `code_o` equals `s ^ (s >> 1)` for the sample `s` presented one clock earlier.
- R3: With differencing on and Gray off, a non-standard valid sample `s` yields `(s - h) mod 1024`, where `h` is the valid sample two valid samples earlier. Cycles without a valid sample do not advance that history.
- R4: With both options on, `code_o` is the Gray mapping of the wrapped difference from R3.
- R5: The valid samples after a detected pulse are numbered from 1. When `cfg_phase_i` holds the value p (bit 0 is its low bit), samples 3+p and 4+p are standard. A standard sample skips differencing but is still Gray-mapped when Gray is on. Positions saturate, so that samples far from a pulse, or samples seen before any pulse since reset, are never standard.
- R6: A pulse is active when `line_ref_i` differs from `cfg_ref_low_i`. Only the inactive-to-active transition restarts numbering, and holding the pulse active does not restart it again. If a valid sample arrives in the cycle of that transition, it is number 1. Otherwise the first later valid sample is number 1.
- R7: With `cfg_ref_fall_i` = 0 the pulse level is taken at the rising clock edge. With 1 it is captured at the falling edge and acted on at the next rising edge. A pulse that is high only around a falling edge is therefore seen in mode 1 and missed in mode 0.
- R8: During reset `code_o` is 0 and the two-sample history is 0, so the first two differenced samples after reset are output unchanged.
- R9: In a cycle without a valid sample, `code_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 10 | Converter sample |
| smp_vld_i | input | 1 | Sample valid strobe |
| line_ref_i | input | 1 | Line reference pulse |
| cfg_gray_i | input | 1 | 1 selects Gray output, 0 selects binary |
| cfg_diff_i | input | 1 | 1 selects differential coding, 0 selects pass-through |
| cfg_phase_i | input | 2 | Position of the standard pair after the pulse |
| cfg_ref_fall_i | input | 1 | 1 samples the pulse on the falling edge |
| cfg_ref_low_i | input | 1 | 1 makes the pulse active low |
| code_o | output | 10 | Registered coded sample |

## Verification
Two functions can land on the same clock edge. First, a pulse's leading edge can arrive in the very cycle that carries a valid sample, so that this sample must be counted as number 1. Second, that sample's coding can flip from differenced to standard while Gray mapping is also active. The bench provokes both by driving the pulse together with a sample across every combination of phase, coding, polarity and capture edge. It also inserts gaps, held pulses and pulses without a sample. A model that numbers samples and keeps its own history from the requirements alone then predicts every output word. A wrong position or a missed Gray stage on a standard sample shows up as a mismatch in that exact cycle.

// File: rtl/dge_pkg.sv
package dge_pkg;
    // First standard position when the phase field is zero.
    localparam int STD_BASE = 3;
    // Number of consecutive standard samples per line.
    localparam int STD_RUN = 2;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } ref_edge_e;
endpackage

// File: rtl/dge_ref_detect.sv
module dge_ref_detect
    import dge_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    input  logic fall_sel_i,
    input  logic act_low_i,
    output logic lead_o
);
    typedef struct packed {
        logic prev;
    } st_t;

    st_t  st_d, st_q;
    logic neg_q;
    logic line_lvl;
    logic act_lvl;

    // Half-cycle capture used when the falling edge is selected.
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) neg_q <= 1'b0;
        else         neg_q <= ref_i;
    end

    always_comb begin
        line_lvl = (ref_edge_e'(fall_sel_i) == EDGE_FALL) ? neg_q : ref_i;
        act_lvl  = line_lvl ^ act_low_i;
        lead_o   = act_lvl & ~st_q.prev;
        st_d     = st_q;
        st_d.prev = act_lvl;
    end

    // Previous level resets active so a pulse held through reset is not a leading edge.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{prev: 1'b1};
        else         st_q <= st_d;
    end
endmodule

// File: rtl/dge_pos_track.sv
module dge_pos_track
    import dge_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lead_i,
    input  logic             vld_i,
    input  logic [1:0]       phase_i,
    output logic             std_o,
    output logic [CNT_W-1:0] pos_o
);
    // CNT_W must leave the saturation value above the last standard slot (>= 4).
    localparam logic [CNT_W-1:0] POS_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] BASE    = CNT_W'(STD_BASE);
    localparam logic [CNT_W-1:0] RUN     = CNT_W'(STD_RUN);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] base_pos;
    logic [CNT_W-1:0] cur_pos;
    logic [CNT_W-1:0] first_pos;
    logic [CNT_W-1:0] last_pos;

    always_comb begin
        base_pos  = lead_i ? '0 : st_q.pos;
        cur_pos   = (base_pos == POS_MAX) ? POS_MAX : base_pos + ONE;
        first_pos = BASE + {{(CNT_W-2){1'b0}}, phase_i};
        last_pos  = first_pos + RUN - ONE;
        std_o     = vld_i && (cur_pos >= first_pos) && (cur_pos <= last_pos);
        st_d      = st_q;
        if (vld_i)       st_d.pos = cur_pos;
        else if (lead_i) st_d.pos = '0;
    end

    // Saturated at reset: no standard data until the first pulse.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{pos: POS_MAX};
        else         st_q <= st_d;
    end

    assign pos_o = st_q.pos;
endmodule

// File: rtl/dge_codec.sv
module dge_codec #(
    parameter int DW = 10
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          vld_i,
    input  logic [DW-1:0] smp_i,
    input  logic          diff_i,
    input  logic          gray_i,
    input  logic          std_i,
    output logic [DW-1:0] code_o
);
    typedef struct packed {
        logic [DW-1:0] h1;
        logic [DW-1:0] h2;
        logic [DW-1:0] code;
    } st_t;

    st_t           st_d, st_q;
    logic [DW-1:0] delta;
    logic [DW-1:0] pre;
    logic [DW-1:0] gray_v;

    // Borrow is dropped: the subtraction wraps in DW bits.
    always_comb begin
        delta = smp_i - st_q.h2;
        pre   = (diff_i && !std_i) ? delta : smp_i;
    end

    for (genvar b = 0; b < DW - 1; b++) begin : g_gray
        assign gray_v[b] = pre[b] ^ pre[b+1];
    end
    assign gray_v[DW-1] = pre[DW-1];

    always_comb begin
        st_d = st_q;
        if (vld_i) begin
            st_d.h1   = smp_i;
            st_d.h2   = st_q.h1;
            st_d.code = gray_i ? gray_v : pre;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign code_o = st_q.code;
endmodule

// File: rtl/diff_gray_encoder.sv
module diff_gray_encoder #(
    parameter int DW    = 10,
    parameter int CNT_W = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] smp_i,
    input  logic          smp_vld_i,
    input  logic          line_ref_i,
    input  logic          cfg_gray_i,
    input  logic          cfg_diff_i,
    input  logic [1:0]    cfg_phase_i,
    input  logic          cfg_ref_fall_i,
    input  logic          cfg_ref_low_i,
    output logic [DW-1:0] code_o
);
    logic             ref_lead;
    logic             std_sel;
    logic [CNT_W-1:0] trk_pos;

    dge_ref_detect u_ref (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ref_i      (line_ref_i),
        .fall_sel_i (cfg_ref_fall_i),
        .act_low_i  (cfg_ref_low_i),
        .lead_o     (ref_lead)
    );

    dge_pos_track #(.CNT_W(CNT_W)) u_trk (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .lead_i  (ref_lead),
        .vld_i   (smp_vld_i),
        .phase_i (cfg_phase_i),
        .std_o   (std_sel),
        .pos_o   (trk_pos)
    );

    dge_codec #(.DW(DW)) u_codec (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .vld_i  (smp_vld_i),
        .smp_i  (smp_i),
        .diff_i (cfg_diff_i),
        .gray_i (cfg_gray_i),
        .std_i  (std_sel),
        .code_o (code_o)
    );
endmodule

// File: rtl/dge_chk.sv
module dge_chk #(
    parameter int DW    = 10,
    parameter int CNT_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [DW-1:0]    smp_i,
    input logic             smp_vld_i,
    input logic             cfg_gray_i,
    input logic             cfg_diff_i,
    input logic [DW-1:0]    code_o,
    input logic             lead,
    input logic [CNT_W-1:0] pos
);
    logic [DW-1:0] ck_h1, ck_h2;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ck_h1 <= '0;
            ck_h2 <= '0;
        end else if (smp_vld_i) begin
            ck_h1 <= smp_i;
            ck_h2 <= ck_h1;
        end
    end

    // R9
    hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !smp_vld_i |=> $stable(code_o));

    // R1
    plain_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_vld_i && !cfg_diff_i && !cfg_gray_i) |=> (code_o == $past(smp_i)));

    // R2
    gray_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_vld_i && !cfg_diff_i && cfg_gray_i)
        |=> (code_o == ($past(smp_i) ^ ($past(smp_i) >> 1))));

    // R3
    diff_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (smp_vld_i && cfg_diff_i && !cfg_gray_i)
        |=> ((code_o == $past(smp_i - ck_h2)) || (code_o == $past(smp_i))));

    // R6
    lead_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lead && !smp_vld_i) |=> (pos == '0));

    // R6
    lead_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lead && smp_vld_i) |=> (pos == CNT_W'(1)));
endmodule

bind diff_gray_encoder dge_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_i      (smp_i),
    .smp_vld_i  (smp_vld_i),
    .cfg_gray_i (cfg_gray_i),
    .cfg_diff_i (cfg_diff_i),
    .code_o     (code_o),
    .lead       (ref_lead),
    .pos        (trk_pos)
);

// File: tb/diff_gray_encoder_bench.sv
module diff_gray_encoder_bench;
    localparam int PERIOD = 10;
    localparam int DW     = 10;
    localparam int CNT_W  = 4;
    localparam int MASK   = (1 << DW) - 1;
    localparam int PMAX   = (1 << CNT_W) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] smp = '0;
    logic          vld = 1'b0;
    logic          ref_l = 1'b0;
    logic          gray = 1'b0;
    logic          diff = 1'b0;
    logic [1:0]    phase = 2'd0;
    logic          fall = 1'b0;
    logic          low = 1'b0;
    logic [DW-1:0] code;

    int checks = 0;
    int errors = 0;
    int m_h1, m_h2, m_pos, m_exp;
    bit m_prev;
    logic [15:0] lf = 16'h1ace;

    always #(PERIOD/2) clk = ~clk;

    diff_gray_encoder #(.DW(DW), .CNT_W(CNT_W)) u_diff_gray_encoder (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .smp_i          (smp),
        .smp_vld_i      (vld),
        .line_ref_i     (ref_l),
        .cfg_gray_i     (gray),
        .cfg_diff_i     (diff),
        .cfg_phase_i    (phase),
        .cfg_ref_fall_i (fall),
        .cfg_ref_low_i  (low),
        .code_o         (code)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int next_rnd();
        lf = {1'b0, lf[15:1]} ^ (lf[0] ? 16'hb400 : 16'h0000);
        return int'(lf[DW-1:0]);
    endfunction

    // One clock: drive at posedge+2, predict, compare at next posedge+2.
    task automatic cyc(input int s, input bit v, input bit r,
                       input bit glitch = 1'b0, input string force_tag = "");
        bit    eff, act, det, stdp;
        int    cur, val;
        string tag;
        smp   = s[DW-1:0];
        vld   = v;
        ref_l = r;
        eff   = glitch ? fall : r;
        act   = eff ^ low;
        det   = act && !m_prev;
        m_prev = act;
        if (v) begin
            cur   = det ? 1 : ((m_pos >= PMAX) ? PMAX : m_pos + 1);
            m_pos = cur;
            stdp  = (cur >= 3 + int'(phase)) && (cur <= 4 + int'(phase));
            val   = (diff && !stdp) ? ((s - m_h2) & MASK) : (s & MASK);
            m_exp = gray ? (val ^ (val >> 1)) : val;
            m_h2  = m_h1;
            m_h1  = s & MASK;
            if (stdp && diff) tag = "R5";
            else if (diff && gray) tag = "R4";
            else if (diff) tag = "R3";
            else if (gray) tag = "R2";
            else tag = "R1";
        end else begin
            if (det) m_pos = 0;
            tag = "R9";
        end
        if (force_tag != "") tag = force_tag;
        if (glitch) begin
            @(negedge clk);
            #2 ref_l = 1'b0;
        end
        @(posedge clk);
        #2;
        check(tag, int'(code), m_exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        vld = 1'b0; ref_l = 1'b0; fall = 1'b0; low = 1'b0;
        gray = 1'b0; diff = 1'b0; phase = 2'd0;
        @(posedge clk);
        #2;
        check("R8", int'(code), 0);
        rst_n = 1'b1;
        m_h1 = 0; m_h2 = 0; m_pos = PMAX; m_prev = 1'b1; m_exp = 0;
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(posedge clk);
        #2;
        do_reset();

        // R8: zero history, so the first two differenced samples pass unchanged
        diff = 1'b1;
        cyc(100, 1, 0, 0, "R8");
        cyc(200, 1, 0, 0, "R8");
        cyc(50, 1, 0);              // R3 wrap: 50-100
        cyc(0, 0, 0);               // R9 gap
        cyc(10, 1, 0);              // R3: history skips the gap
        // no pulse since reset: positions saturated, never standard (R5)
        for (int i = 0; i < 10; i++) cyc(i * 37, 1, 0, 0, "R5");

        // R1 / R2 exhaustive sample sweep
        diff = 1'b0;
        for (int g = 0; g < 2; g++) begin
            gray = g[0];
            for (int s = 0; s <= MASK; s++) cyc(s, 1, 0);
        end

        // R3 / R4 random sweep with gaps
        diff = 1'b1;
        for (int g = 0; g < 2; g++) begin
            gray = g[0];
            for (int i = 0; i < 400; i++) cyc(next_rnd(), (i % 5) != 3, 0);
        end

        // R5 / R6 line sweep over every configuration
        for (int c = 0; c < 64; c++) begin
            diff  = c[0];
            gray  = c[1];
            phase = c[3:2];
            low   = c[4];
            fall  = c[5];
            cyc(next_rnd(), 1, low);
            cyc(next_rnd(), 1, low);
            if (c % 3 == 0) begin
                cyc(0, 0, !low, 0, "R6");   // pulse without a sample
                cyc(0, 0, low);
            end else begin
                for (int h = 0; h < 1 + (c % 4); h++) cyc(next_rnd(), 1, !low);
            end
            for (int i = 0; i < 12; i++) cyc(next_rnd(), (i != 4) || (c % 2 == 0), low);
        end

        // R6: held pulse restarts only once, second pulse restarts again
        low = 1'b0; fall = 1'b0; diff = 1'b1; gray = 1'b0; phase = 2'd1;
        cyc(300, 1, 0);
        for (int i = 0; i < 8; i++) cyc(next_rnd(), 1, 1, 0, "R6");
        for (int i = 0; i < 4; i++) cyc(next_rnd(), 1, 0, 0, "R6");
        for (int i = 0; i < 8; i++) cyc(next_rnd(), 1, (i < 2), 0, "R6");

        // R7: narrow pulse around the falling edge
        phase = 2'd0;
        for (int f = 0; f < 2; f++) begin
            fall = f[0];
            for (int i = 0; i < 20; i++) cyc(next_rnd(), 1, 0);
            cyc(next_rnd(), 1, 1, 1, "R7");
            for (int i = 0; i < 8; i++) cyc(next_rnd(), 1, 0, 0, "R7");
        end

        // R8: reset mid-stream clears history and output
        do_reset();
        diff = 1'b1; gray = 1'b1;
        cyc(700, 1, 0, 0, "R8");
        cyc(5, 1, 0, 0, "R8");
        cyc(6, 1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule